// File: doc/BRIEF.md
# SDRAM Burst Read Sequencer

This block sits between a cache-fill client and a simplified SDRAM read port. The client hands over a start byte address and a byte count that is a whole number of bursts. The sequencer splits the request into fixed-length bursts of eight 32-bit beats, which is 32 bytes per burst. For each burst it raises a one-cycle read command with the burst address. It then counts the access latency itself and forwards each returning word to the client, tagged with a valid strobe and its index within the burst.

Each burst is independent of the others. The next read command goes out in the cycle after the previous burst's eighth beat, and every burst pays the full initial latency again. A 64-byte request therefore takes exactly twice as long as a 32-byte one, while the wait for the first word is the same for both.

Requests are taken only while the sequencer is idle, through a ready/valid handshake. A byte count that is zero or not a multiple of 32 raises an error pulse, and the request is dropped.

Top module: `sdr_burst_reader`

## Requirements
- R1: `req_ready` is high exactly when the sequencer is idle. While it is high, no read command, no data beat and no done pulse appear.
- R2: A request with a valid length is accepted on a clock edge where `req_valid` and `req_ready` are both high. `mem_rd` is then high in the next cycle, for exactly one cycle, with `mem_addr` equal to the request address.
- R3: The first beat of a burst appears LAT cycles after its `mem_rd` cycle (LAT defaults to 5). The eight beats follow on consecutive cycles with `out_idx` running from 0 to 7, so one burst spans 13 cycles from its command to its last beat.
- R4: During a beat cycle, `out_data` equals `mem_rdata` in that same cycle.
- R5: A request of N bursts (N = bytes/32) issues N read commands. Each command follows the previous burst's beat 7 by one cycle, and its address is 32 bytes above the previous one. The whole request spans 13·N cycles from the first command to the last beat.
- R6: `out_last` is high only on beat 7 of the final burst of a request.
- R7: `done` pulses for one cycle in the cycle after the final beat. `req_ready` returns high in the cycle after `done`.
- R8: A handshake whose byte count is zero, or not a multiple of 32, produces an `err` pulse in the next cycle. In that case no read command is issued and `req_ready` stays high.
- R9: After reset, `req_ready` is 1 and `mem_rd`, `out_valid`, `out_last`, `done` and `err` are all 0.
- R10: Raising `req_valid` while a request is in progress has no effect. The command, beat and done timing of the current request are unchanged, and no extra command appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_addr | input | ADDR_W | Start byte address |
| req_bytes | input | LEN_W | Byte count, a multiple of 32 |
| err | output | 1 | One-cycle pulse: rejected byte count |
| mem_rd | output | 1 | One-cycle burst read command |
| mem_addr | output | ADDR_W | Byte address of the burst being issued |
| mem_rdata | input | DATA_W | Read data from the memory |
| out_valid | output | 1 | Beat valid strobe to the client |
| out_data | output | DATA_W | Beat data |
| out_idx | output | 3 | Beat index within the burst, 0 to 7 |
| out_last | output | 1 | Final beat of the whole request |
| done | output | 1 | One-cycle pulse after the final beat |

## Verification
Directed runs of one burst and of two bursts check that the first-word latency is identical in both cases and that the two-burst request ends exactly 13 cycles later, which separates a correct design from one that streams the bursts back to back or that skips the repeated latency. Zero, 33 and 48 byte counts separate correct length validation from a check that only looks at the low bits or only rejects zero. Random mixes of valid and invalid lengths at random addresses cover address stepping across bursts and the error path. Some of these runs hold `req_valid` high while the sequencer is busy, to show that a request offered mid-run is ignored.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_RUN   = 2'd2,
        ST_DONE  = 2'd3
    } seq_state_e;

    // A byte count is usable when it is non-zero and a whole number of bursts.
    function automatic logic len_fits(input logic [31:0] nbytes, input int burst_bytes);
        return (nbytes != 32'd0) && ((nbytes % 32'(burst_bytes)) == 32'd0);
    endfunction

endpackage

// File: rtl/sbr_beat_timer.sv
module sbr_beat_timer #(
    parameter int LAT   = 5,
    parameter int BEATS = 8,
    parameter int IDX_W = $clog2(BEATS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             beat_valid,
    output logic [IDX_W-1:0] beat_idx,
    output logic             burst_end
);
    localparam int CNT_MAX = LAT + BEATS - 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic             active;
    logic [CNT_W-1:0] cnt;

    // cnt holds the number of cycles elapsed since the command cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (start) begin
            active <= 1'b1;
            cnt    <= CNT_W'(1);
        end else if (active) begin
            if (cnt == CNT_W'(CNT_MAX)) begin
                active <= 1'b0;
                cnt    <= '0;
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    always_comb begin
        beat_valid = active && (cnt >= CNT_W'(LAT));
        beat_idx   = IDX_W'(cnt - CNT_W'(LAT));
        burst_end  = beat_valid && (cnt == CNT_W'(CNT_MAX));
    end

endmodule

// File: rtl/sbr_seq_ctl.sv
module sbr_seq_ctl
    import sbr_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int LEN_W       = 12,
    parameter int BURST_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_bytes,
    input  logic              burst_end,
    output logic              issue,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              final_burst,
    output logic              done,
    output logic              err
);
    localparam int SHIFT = $clog2(BURST_BYTES);

    seq_state_e        st;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  left_q;
    logic              err_q;
    logic              take;
    logic              ok;

    always_comb begin
        take = req_valid && (st == ST_IDLE);
        ok   = len_fits(32'(req_bytes), BURST_BYTES);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            addr_q <= '0;
            left_q <= '0;
            err_q  <= 1'b0;
        end else begin
            err_q <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (take) begin
                        if (ok) begin
                            addr_q <= req_addr;
                            left_q <= req_bytes >> SHIFT;
                            st     <= ST_ISSUE;
                        end else begin
                            err_q <= 1'b1;
                        end
                    end
                end
                ST_ISSUE: st <= ST_RUN;
                ST_RUN: begin
                    if (burst_end) begin
                        if (left_q == LEN_W'(1)) begin
                            st <= ST_DONE;
                        end else begin
                            left_q <= left_q - LEN_W'(1);
                            addr_q <= addr_q + ADDR_W'(BURST_BYTES);
                            st     <= ST_ISSUE;
                        end
                    end
                end
                ST_DONE: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        req_ready   = (st == ST_IDLE);
        issue       = (st == ST_ISSUE);
        cur_addr    = addr_q;
        final_burst = (left_q == LEN_W'(1));
        done        = (st == ST_DONE);
        err         = err_q;
    end

endmodule

// File: rtl/sdr_burst_reader.sv
module sdr_burst_reader #(
    parameter int ADDR_W = 24,
    parameter int LEN_W  = 12,
    parameter int DATA_W = 32,
    parameter int BEATS  = 8,
    parameter int LAT    = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_bytes,
    output logic              err,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic [$clog2(BEATS)-1:0] out_idx,
    output logic              out_last,
    output logic              done
);
    localparam int IDX_W       = $clog2(BEATS);
    localparam int BURST_BYTES = BEATS * DATA_W / 8;

    logic             issue;
    logic             burst_end;
    logic             final_burst;
    logic             beat_valid;
    logic [IDX_W-1:0] beat_idx;

    sbr_seq_ctl #(
        .ADDR_W     (ADDR_W),
        .LEN_W      (LEN_W),
        .BURST_BYTES(BURST_BYTES)
    ) u_ctl (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_addr   (req_addr),
        .req_bytes  (req_bytes),
        .burst_end  (burst_end),
        .issue      (issue),
        .cur_addr   (mem_addr),
        .final_burst(final_burst),
        .done       (done),
        .err        (err)
    );

    sbr_beat_timer #(
        .LAT  (LAT),
        .BEATS(BEATS),
        .IDX_W(IDX_W)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .start     (issue),
        .beat_valid(beat_valid),
        .beat_idx  (beat_idx),
        .burst_end (burst_end)
    );

    always_comb begin
        mem_rd    = issue;
        out_valid = beat_valid;
        out_idx   = beat_idx;
        out_data  = mem_rdata;
        out_last  = burst_end && final_burst;
    end

endmodule

// File: rtl/sbr_checker.sv
module sbr_checker
    import sbr_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int LEN_W  = 12,
    parameter int BEATS  = 8,
    parameter int LAT    = 5,
    parameter int BURST_BYTES = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic [LEN_W-1:0]  req_bytes,
    input logic              err,
    input logic              mem_rd,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              out_valid,
    input logic [$clog2(BEATS)-1:0] out_idx,
    input logic              out_last,
    input logic              done
);
    localparam int IDX_W = $clog2(BEATS);

    // cycles since the last read command, saturating
    logic [7:0] since_rd;
    always_ff @(posedge clk) begin
        if (rst)                     since_rd <= '0;
        else if (mem_rd)             since_rd <= 8'd1;
        else if (since_rd != '0 && since_rd != 8'hFF) since_rd <= since_rd + 8'd1;
    end

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!mem_rd && !out_valid && !done));

    a_r2_cmd_after_accept: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && len_fits(32'(req_bytes), BURST_BYTES))
        |=> (mem_rd && mem_addr == $past(req_addr)));

    a_r3_first_beat_latency: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_idx == '0) |-> (since_rd == 8'(LAT)));

    a_r3_idx_steps: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_idx != IDX_W'(BEATS - 1))
        |=> (out_valid && out_idx == $past(out_idx) + IDX_W'(1)));

    a_r5_next_cmd: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_idx == IDX_W'(BEATS - 1) && !out_last) |=> mem_rd);

    a_r6_last_on_final_idx: assert property (@(posedge clk) disable iff (rst)
        out_last |-> (out_valid && out_idx == IDX_W'(BEATS - 1)));

    a_r7_done_follows_last: assert property (@(posedge clk) disable iff (rst)
        out_last |=> (done && !out_valid));

    a_r8_reject: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !len_fits(32'(req_bytes), BURST_BYTES))
        |=> (err && req_ready && !mem_rd));

endmodule

bind sdr_burst_reader sbr_checker #(
    .ADDR_W     (ADDR_W),
    .LEN_W      (LEN_W),
    .BEATS      (BEATS),
    .LAT        (LAT),
    .BURST_BYTES(BURST_BYTES)
) u_sbr_checker (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_addr (req_addr),
    .req_bytes(req_bytes),
    .err      (err),
    .mem_rd   (mem_rd),
    .mem_addr (mem_addr),
    .out_valid(out_valid),
    .out_idx  (out_idx),
    .out_last (out_last),
    .done     (done)
);

// File: tb/tb_sdr_burst_reader.sv
module tb_sdr_burst_reader;
    localparam int ADDR_W = 24;
    localparam int LEN_W  = 12;
    localparam int DATA_W = 32;
    localparam int BEATS  = 8;
    localparam int LAT    = 5;
    localparam int SPAN   = LAT + BEATS;

    logic              clk = 1'b0;
    logic              rst;
    logic              req_valid;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr;
    logic [LEN_W-1:0]  req_bytes;
    logic              err;
    logic              mem_rd;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_rdata;
    logic              out_valid;
    logic [DATA_W-1:0] out_data;
    logic [2:0]        out_idx;
    logic              out_last;
    logic              done;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    sdr_burst_reader #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W), .BEATS(BEATS), .LAT(LAT)
    ) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_bytes(req_bytes), .err(err), .mem_rd(mem_rd),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .out_valid(out_valid),
        .out_data(out_data), .out_idx(out_idx), .out_last(out_last), .done(done)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [DATA_W-1:0] pat(input logic [ADDR_W-1:0] a, input int beat);
        return (32'(a) * 32'h9E37_79B1) ^ (32'(beat) << 27) ^ 32'h5A5A_0000;
    endfunction

    function automatic logic good_len(input int b);
        return (b != 0) && (b % 32 == 0);
    endfunction

    // flags packed as {mem_rd, out_valid, out_last, done, req_ready, err}
    task automatic run_req(input logic [ADDR_W-1:0] a, input int nbytes, input logic poke);
        int nb;
        @(negedge clk);
        chk("R1 ready before request", 64'(req_ready), 64'd1);
        req_valid = 1'b1;
        req_addr  = a;
        req_bytes = LEN_W'(nbytes);
        @(negedge clk);
        req_valid = 1'b0;
        if (!good_len(nbytes)) begin
            #1;
            chk("R8 reject flags", 64'({mem_rd, out_valid, out_last, done, req_ready, err}),
                64'(6'b000011));
            @(negedge clk);
            #1;
            chk("R8 err single pulse", 64'({mem_rd, err, req_ready}), 64'(3'b001));
            return;
        end
        nb = nbytes / 32;
        for (int n = 0; n <= SPAN * nb; n++) begin
            int b = n / SPAN;
            int k = n % SPAN;
            logic in_run = (n < SPAN * nb);
            logic e_rd   = in_run && (k == 0);
            logic e_val  = in_run && (k >= LAT);
            logic e_last = e_val && (b == nb - 1) && (k == SPAN - 1);
            logic e_done = (n == SPAN * nb);
            logic [ADDR_W-1:0] ba = a + ADDR_W'(32 * b);
            if (poke && n == 2) begin
                req_valid = 1'b1; req_addr = ~a; req_bytes = LEN_W'(32);
            end
            if (poke && n == SPAN * nb - 1) req_valid = 1'b0;
            mem_rdata = e_val ? pat(ba, k - LAT) : 32'hDEAD_BEEF;
            #1;
            chk(poke ? "R10 timing with req_valid held" : "R5 per-cycle flags",
                64'({mem_rd, out_valid, out_last, done, req_ready, err}),
                64'({e_rd, e_val, e_last, e_done, 1'b0, 1'b0}));
            if (e_rd)
                chk(b == 0 ? "R2 first command address" : "R5 next burst address",
                    64'(mem_addr), 64'(ba));
            if (e_val) begin
                chk("R3 beat index", 64'(out_idx), 64'(k - LAT));
                chk("R4 beat data", 64'(out_data), 64'(pat(ba, k - LAT)));
            end
            if (e_val && k == LAT)
                chk("R3 first beat latency", 64'(k), 64'(LAT));
            if (e_last) chk("R6 last on final beat", 64'(out_last), 64'd1);
            if (e_done) chk("R7 done at 13*N", 64'(n), 64'(SPAN * nb));
            @(negedge clk);
        end
        #1;
        chk("R7 ready after done", 64'({req_ready, done, out_valid}), 64'(3'b100));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h1F2E_3D4C));
        rst = 1'b1; req_valid = 1'b0; req_addr = '0; req_bytes = '0; mem_rdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R9 reset state", 64'({req_ready, mem_rd, out_valid, out_last, done, err}),
            64'(6'b100000));

        run_req(24'h000100, 32, 1'b0);     // single burst
        run_req(24'h000400, 64, 1'b0);     // two bursts, double duration
        run_req(24'h001000, 0, 1'b0);      // R8 zero length
        run_req(24'h001000, 48, 1'b0);     // R8 not a multiple
        run_req(24'h001000, 33, 1'b0);     // R8 odd count
        run_req(24'h002000, 96, 1'b1);     // R10 request offered while busy
        run_req(24'hFFFFE0, 64, 1'b0);     // address wrap

        for (int i = 0; i < 25; i++) begin
            logic [ADDR_W-1:0] a = ADDR_W'($urandom);
            int nbytes;
            if ($urandom_range(2, 0) != 0) nbytes = 32 * $urandom_range(6, 1);
            else nbytes = $urandom_range(300, 0);
            run_req(a, nbytes, ($urandom_range(3, 0) == 0));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule